// File: doc/BRIEF.md
# Power-On and Watchdog Reset Supervisor

This block drives the system reset request for a microcontroller-based unit. Two events can cause a reset. The first is power being applied: while the power-good input is low, the reset request is held active. Once power-good rises, the reset request stays active for a long hold interval, counted in state-time ticks, and is then released. The second is a watchdog that cannot be turned off. After release, the watchdog counts every state-time tick. Software must pulse a clear input before the count reaches its terminal value. If it does not, the block issues a short reset pulse of a fixed number of ticks.

The reset request is active low and is meant to drive an open-drain style system reset net. A cause flag shows whether the most recent reset came from power-on (0) or from the watchdog (1). The flag is still readable after the reset has been released. The watchdog count is held at zero during any reset and restarts from zero each time a reset is released.

Top module: `rst_supervisor`

## Requirements
- R1: While `pwrGood` is low, `rstReqN` is 0 and `causeWdog` is 0, and all internal counts are cleared.
- R2: After `pwrGood` rises, `rstReqN` stays 0 until POR_TICKS clock edges with `tickEn` high have been counted. It goes to 1 on the POR_TICKS-th such edge. Edges with `tickEn` low are not counted.
- R3: Once released, the watchdog counts clock edges with `tickEn` high. If no clear occurs, `rstReqN` falls on the WD_TIMEOUT-th ticked edge. Edges with `tickEn` low do not advance the count.
- R4: A watchdog reset keeps `rstReqN` at 0 for exactly WD_PULSE ticked edges and then releases it.
- R5: A clock edge with `wdClear` high while released sets the watchdog count to zero. The next expiry then needs WD_TIMEOUT further ticked edges.
- R6: If `wdClear` is high on the same edge on which the count is at terminal value with `tickEn` high, the clear wins and no reset is issued.
- R7: `wdClear` has no effect while any reset is active. Neither the power-on hold nor the watchdog pulse is shortened. The watchdog count starts from zero when a reset is released.
- R8: `causeWdog` goes to 1 on a watchdog expiry. It keeps that value through release and through later expiries, and only `pwrGood` low returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwrGood | input | 1 | Power-good, active high; low is an asynchronous reset |
| tickEn | input | 1 | One-cycle strobe marking each state-time tick |
| wdClear | input | 1 | Software watchdog service strobe |
| rstReqN | output | 1 | System reset request, active low |
| causeWdog | output | 1 | Cause of last reset: 1 watchdog, 0 power-on |

## Verification
The hardest case to reach is a clear that lands exactly on the terminal-count tick. Only at that point does the clear-over-expiry priority decide whether a reset happens. From the ports it can only be hit by counting ticked edges exactly from the release edge. The bench therefore uses short parameter values and drives a fixed number of ticked cycles, WD_TIMEOUT-1 of them, after a known release. It then raises `wdClear` together with the tick on the very next edge. It follows this with a full timeout to confirm the count restarted from zero.

// File: rtl/rst_supervisor_pkg.sv
package rst_supervisor_pkg;

  typedef enum logic [1:0] {
    ST_POR_HOLD = 2'd0,
    ST_RUN      = 2'd1,
    ST_WD_PULSE = 2'd2
  } sup_state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic phaseClr;   // zero the phase (hold/pulse) counter
    logic phaseInc;   // advance the phase counter
    logic phasePulse; // compare against pulse length instead of hold length
    logic wdClr;      // zero the watchdog counter
    logic wdInc;      // advance the watchdog counter
  } sup_strobe_t;

endpackage

// File: rtl/rst_supervisor_dp.sv
module rst_supervisor_dp
  import rst_supervisor_pkg::*;
#(
  parameter int POR_TICKS  = 100000,
  parameter int WD_TIMEOUT = 65536,
  parameter int WD_PULSE   = 16
) (
  input  logic        clk,
  input  logic        pwrGood,
  input  sup_strobe_t strobe,
  output logic        phaseDone,
  output logic        wdTerm
);

  localparam int PH_MAX = (POR_TICKS > WD_PULSE) ? POR_TICKS : WD_PULSE;
  localparam int PH_W   = (PH_MAX > 2) ? $clog2(PH_MAX) : 1;
  localparam int WD_W   = (WD_TIMEOUT > 2) ? $clog2(WD_TIMEOUT) : 1;
  localparam logic [PH_W-1:0] POR_LAST   = PH_W'(POR_TICKS - 1);
  localparam logic [PH_W-1:0] PULSE_LAST = PH_W'(WD_PULSE - 1);
  localparam logic [WD_W-1:0] WD_LAST    = WD_W'(WD_TIMEOUT - 1);

  logic [PH_W-1:0] phaseCnt;
  logic [WD_W-1:0] wdCnt;

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) begin
      phaseCnt <= '0;
    end else if (strobe.phaseClr) begin
      phaseCnt <= '0;
    end else if (strobe.phaseInc) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) begin
      wdCnt <= '0;
    end else if (strobe.wdClr) begin
      wdCnt <= '0;
    end else if (strobe.wdInc) begin
      wdCnt <= wdCnt + 1'b1;
    end
  end

  assign phaseDone = strobe.phasePulse ? (phaseCnt == PULSE_LAST)
                                       : (phaseCnt == POR_LAST);
  assign wdTerm    = (wdCnt == WD_LAST);

  // A clear strobe leaves the watchdog count at zero (R5)
  p_clear_zeroes_r5: assert property (@(posedge clk) disable iff (!pwrGood)
    strobe.wdClr |=> (wdCnt == '0));

  // An increment never walks past terminal count: expiry must intervene (R3)
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!pwrGood)
    (strobe.wdInc && !strobe.wdClr) |-> (wdCnt != WD_LAST));

endmodule

// File: rtl/rst_supervisor_ctrl.sv
module rst_supervisor_ctrl
  import rst_supervisor_pkg::*;
(
  input  logic        clk,
  input  logic        pwrGood,
  input  logic        tickEn,
  input  logic        wdClear,
  input  logic        phaseDone,
  input  logic        wdTerm,
  output sup_strobe_t strobe,
  output logic        rstReqN,
  output logic        causeWdog
);

  sup_state_t state, nextState;
  logic       expire;

  always_comb begin
    nextState = state;
    strobe    = '0;
    expire    = 1'b0;
    unique case (state)
      ST_POR_HOLD: begin
        strobe.wdClr = 1'b1;
        if (tickEn) begin
          if (phaseDone) begin
            nextState       = ST_RUN;
            strobe.phaseClr = 1'b1;
          end else begin
            strobe.phaseInc = 1'b1;
          end
        end
      end
      ST_RUN: begin
        strobe.phaseClr = 1'b1;
        if (wdClear) begin
          strobe.wdClr = 1'b1;          // clear outranks terminal count
        end else if (tickEn) begin
          if (wdTerm) begin
            nextState    = ST_WD_PULSE;
            strobe.wdClr = 1'b1;
            expire       = 1'b1;
          end else begin
            strobe.wdInc = 1'b1;
          end
        end
      end
      ST_WD_PULSE: begin
        strobe.wdClr      = 1'b1;
        strobe.phasePulse = 1'b1;
        if (tickEn) begin
          if (phaseDone) begin
            nextState       = ST_RUN;
            strobe.phaseClr = 1'b1;
          end else begin
            strobe.phaseInc = 1'b1;
          end
        end
      end
      default: begin
        nextState = ST_POR_HOLD;
      end
    endcase
  end

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) begin
      state     <= ST_POR_HOLD;
      causeWdog <= 1'b0;
    end else begin
      state <= nextState;
      if (expire) begin
        causeWdog <= 1'b1;
      end
    end
  end

  assign rstReqN = (state == ST_RUN);

  // The cause flag never drops while power stays good (R8)
  p_cause_sticky_r8: assert property (@(posedge clk) disable iff (!pwrGood)
    causeWdog |=> causeWdog);

  // Release of reset only ever happens on a tick (R2, R4)
  p_release_on_tick_r4: assert property (@(posedge clk) disable iff (!pwrGood)
    $rose(rstReqN) |-> $past(tickEn));

  // A clear request while released never leads into a watchdog pulse (R6)
  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!pwrGood)
    (rstReqN && wdClear) |=> rstReqN);

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rst_supervisor_pkg::*;
#(
  parameter int POR_TICKS  = 100000,
  parameter int WD_TIMEOUT = 65536,
  parameter int WD_PULSE   = 16
) (
  input  logic clk,
  input  logic pwrGood,
  input  logic tickEn,
  input  logic wdClear,
  output logic rstReqN,
  output logic causeWdog
);

  sup_strobe_t strobe;
  logic        phaseDone;
  logic        wdTerm;

  rst_supervisor_ctrl u_ctrl (
    .clk       (clk),
    .pwrGood   (pwrGood),
    .tickEn    (tickEn),
    .wdClear   (wdClear),
    .phaseDone (phaseDone),
    .wdTerm    (wdTerm),
    .strobe    (strobe),
    .rstReqN   (rstReqN),
    .causeWdog (causeWdog)
  );

  rst_supervisor_dp #(
    .POR_TICKS  (POR_TICKS),
    .WD_TIMEOUT (WD_TIMEOUT),
    .WD_PULSE   (WD_PULSE)
  ) u_dp (
    .clk       (clk),
    .pwrGood   (pwrGood),
    .strobe    (strobe),
    .phaseDone (phaseDone),
    .wdTerm    (wdTerm)
  );

  // Any reset entered after power-up is a watchdog reset (R3, R8)
  p_fall_is_wdog_r3: assert property (@(posedge clk) disable iff (!pwrGood)
    $fell(rstReqN) |-> causeWdog);

  // Watchdog count is parked at zero whenever reset is active (R7)
  p_hold_zero_r7: assert property (@(posedge clk) disable iff (!pwrGood)
    !rstReqN |-> (u_dp.wdCnt == '0));

endmodule

// File: tb/rst_supervisor_bench.sv
module rst_supervisor_bench;

  localparam int POR = 40;
  localparam int TO  = 64;
  localparam int PUL = 16;

  logic clk = 1'b0;
  logic pwrGood = 1'b0;
  logic tickEn = 1'b0;
  logic wdClear = 1'b0;
  logic rstReqN;
  logic causeWdog;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  rst_supervisor #(
    .POR_TICKS  (POR),
    .WD_TIMEOUT (TO),
    .WD_PULSE   (PUL)
  ) u_rst_supervisor (
    .clk       (clk),
    .pwrGood   (pwrGood),
    .tickEn    (tickEn),
    .wdClear   (wdClear),
    .rstReqN   (rstReqN),
    .causeWdog (causeWdog)
  );

  task automatic check(input string tag, input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, actual, expected, $time);
    end
  endtask

  // Drive n clock edges with the given inputs; returns at a falling edge
  task automatic run(input int n, input logic tk, input logic clr);
    for (int i = 0; i < n; i++) begin
      tickEn  = tk;
      wdClear = clr;
      @(posedge clk);
      @(negedge clk);
    end
    tickEn  = 1'b0;
    wdClear = 1'b0;
  endtask

  task automatic t_reset();
    pwrGood = 1'b0;
    run(3, 1'b1, 1'b1);
    check("R1 reset rstReqN", rstReqN, 1'b0);
    check("R1 reset causeWdog", causeWdog, 1'b0);
  endtask

  task automatic t_por();
    pwrGood = 1'b1;
    run(7, 1'b0, 1'b0);
    check("R2 no tick no count", rstReqN, 1'b0);
    run(POR - 1, 1'b1, 1'b0);
    check("R2 hold before last tick", rstReqN, 1'b0);
    run(1, 1'b1, 1'b0);
    check("R2 release on last tick", rstReqN, 1'b1);
    check("R8 power-on cause", causeWdog, 1'b0);
  endtask

  task automatic t_expire();
    run(30, 1'b0, 1'b0);
    check("R3 idle ticks no expiry", rstReqN, 1'b1);
    run(TO - 1, 1'b1, 1'b0);
    check("R3 before timeout", rstReqN, 1'b1);
    run(1, 1'b1, 1'b0);
    check("R3 expiry", rstReqN, 1'b0);
    check("R8 watchdog cause", causeWdog, 1'b1);
    run(PUL - 1, 1'b1, 1'b0);
    check("R4 pulse still low", rstReqN, 1'b0);
    run(1, 1'b1, 1'b0);
    check("R4 pulse ends", rstReqN, 1'b1);
    check("R8 cause kept", causeWdog, 1'b1);
  endtask

  task automatic t_clear();
    run(TO - 10, 1'b1, 1'b0);
    run(1, 1'b1, 1'b1);
    run(TO - 1, 1'b1, 1'b0);
    check("R5 restart after clear", rstReqN, 1'b1);
    run(1, 1'b1, 1'b0);
    check("R5 full timeout after clear", rstReqN, 1'b0);
    run(PUL, 1'b1, 1'b0);
    check("R4 second pulse ends", rstReqN, 1'b1);
  endtask

  task automatic t_terminal();
    run(TO - 1, 1'b1, 1'b0);
    run(1, 1'b1, 1'b1);
    check("R6 clear at terminal", rstReqN, 1'b1);
    run(TO - 1, 1'b1, 1'b0);
    check("R6 count restarted", rstReqN, 1'b1);
    run(1, 1'b1, 1'b0);
    check("R6 later expiry", rstReqN, 1'b0);
    run(PUL, 1'b1, 1'b0);
  endtask

  task automatic t_ignore();
    run(TO, 1'b1, 1'b0);
    check("R7 expiry before ignore", rstReqN, 1'b0);
    run(4, 1'b1, 1'b1);
    run(PUL - 5, 1'b1, 1'b0);
    check("R7 pulse not shortened", rstReqN, 1'b0);
    run(1, 1'b1, 1'b0);
    check("R7 pulse length kept", rstReqN, 1'b1);
    run(TO - 1, 1'b1, 1'b0);
    check("R7 count from zero", rstReqN, 1'b1);
    run(1, 1'b1, 1'b0);
    check("R7 timeout after pulse", rstReqN, 1'b0);
    run(PUL, 1'b1, 1'b0);
    check("R8 cause after repeat", causeWdog, 1'b1);
  endtask

  task automatic t_power_cycle();
    pwrGood = 1'b0;
    run(2, 1'b0, 1'b0);
    check("R1 power drop rstReqN", rstReqN, 1'b0);
    check("R8 power drop clears cause", causeWdog, 1'b0);
    pwrGood = 1'b1;
    run(10, 1'b1, 1'b1);
    run(POR - 11, 1'b1, 1'b0);
    check("R7 hold not shortened", rstReqN, 1'b0);
    run(1, 1'b1, 1'b0);
    check("R7 hold released", rstReqN, 1'b1);
    run(TO - 1, 1'b1, 1'b0);
    check("R7 fresh count after hold", rstReqN, 1'b1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog timeout actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_por();
    t_expire();
    t_clear();
    t_terminal();
    t_ignore();
    t_power_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule